// File: doc/BRIEF.md
# SD Host Transfer-Mode Control Unit

This block keeps the transfer-mode control word for an SD/MMC host controller. It also follows how many data blocks are left in the current transfer. Software writes the control word over a simple write port. While the data line is busy, the unit refuses those writes, so the settings for the transfer in progress cannot change part way through. The unit decodes and exposes five fields:
- the completion-signal mode,
- the multi-block select,
- the transfer direction,
- the automatic stop-command enable,
- a full readback of the word, with every unused bit held at zero.

The command engine pulses a start input when it issues a command that moves data. In multi-block mode the unit then loads a block counter from the block count input. After that, each block-done strobe from the data path brings the transfer one block closer to its end. When the last block finishes, the unit raises a sticky transfer-complete flag. If the transfer was multi-block with automatic stop enabled, the unit also sends the command engine a single-cycle request to issue the stop command (CMD12).

Top module: `sd_xfer_mode_ctrl`

## Requirements
- R1: After reset every output is 0: the readback word, all decoded fields, the stop request and the complete flag.
- R2: A write with `dat_inhibit_i` low is stored and shows on `mode_o` on the next cycle. The field positions are: bits [9:8] completion-signal mode (00 normal, 01 signal with a data transfer, 10 signal without a data transfer, 11 abort signal), bit 5 multi-block (1 multi, 0 single), bit 4 direction (1 card-to-host read, 0 host-to-card write), bit 2 auto-stop enable.
- R3: The reserved bits [15:10], [7:6], [3], [1] and [0] always read back as 0, whatever value is written.
- R4: A write made while `dat_inhibit_i` is 1 has no effect on `mode_o` or on any decoded field.
- R5: With bit 5 at 0, a transfer is exactly one block. The first block-done after start sets `xfer_done_o`, and `blk_cnt_i` is ignored.
- R6: With bit 5 at 1 and a block count N > 0, `xfer_done_o` rises in the cycle after the N-th block-done strobe and not earlier.
- R7: When bits 5 and 2 were both 1 at transfer start, `stop_req_o` is high for exactly one cycle, the same cycle in which `xfer_done_o` rises after the final block.
- R8: `stop_req_o` never fires for a single-block transfer, or when bit 2 was 0 at transfer start.
- R9: A multi-block start with `blk_cnt_i` = 0 sets `xfer_done_o` on the next cycle and issues no stop request.
- R10: A start pulse clears `xfer_done_o` on the next cycle, except in the zero-count case of R9. The mode settings are captured at start and govern the whole transfer. If start and block-done arrive in the same cycle, start wins.
- R11: A block-done strobe while no transfer is active changes neither `xfer_done_o` nor `stop_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| dat_inhibit_i | input | 1 | Data line busy; blocks writes |
| xfer_start_i | input | 1 | Data command issued; starts a transfer |
| blk_cnt_i | input | CNT_W | Block count for multi-block transfers |
| blk_done_i | input | 1 | One data block finished |
| mode_o | output | 16 | Register readback, reserved bits zero |
| ccs_mode_o | output | 2 | Completion-signal mode field |
| multi_blk_o | output | 1 | Multi-block select |
| dir_read_o | output | 1 | Direction, 1 = card to host |
| auto_stop_en_o | output | 1 | Auto-stop enable |
| stop_req_o | output | 1 | One-cycle request to issue CMD12 |
| xfer_done_o | output | 1 | Transfer complete, sticky until next start |

## Verification
The bench targets the following mistakes:
- A design that lets a write through while the busy input is high would change `mode_o` in the middle of a transfer.
- One that decides "last block" with an off-by-one would raise the complete flag a strobe early or late, and would time the stop request wrong along with it.
- A zero block count in multi-block mode is forced. A naive counter would wrap there and hang the transfer, or send a stray stop command.
- Single-block transfers with auto-stop set, and strobes that arrive with no transfer active, check that the stop request stays low when it must.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;
  localparam int unsigned REG_W = 16;

  localparam int unsigned CCS_LSB  = 8;
  localparam int unsigned MULTI_B  = 5;
  localparam int unsigned DIR_B    = 4;
  localparam int unsigned ASTOP_B  = 2;

  localparam logic [REG_W-1:0] RW_MASK =
      (16'h3 << CCS_LSB) | (16'h1 << MULTI_B) | (16'h1 << DIR_B) | (16'h1 << ASTOP_B);

  typedef enum logic [1:0] {
    CCS_NONE  = 2'b00,
    CCS_DATA  = 2'b01,
    CCS_NODAT = 2'b10,
    CCS_ABORT = 2'b11
  } ccs_mode_e;

  typedef struct packed {
    ccs_mode_e ccs;
    logic      multi;
    logic      dir_read;
    logic      auto_stop;
  } xfer_fields_t;
endpackage

// File: rtl/sd_xfer_mode_reg.sv
module sd_xfer_mode_reg
  import sd_xfer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             dat_inhibit_i,
  output logic [REG_W-1:0] mode_o,
  output xfer_fields_t     fields_o
);
  logic [REG_W-1:0] mode_q;
  logic             wr_ok;

  assign wr_ok = wr_en_i & ~dat_inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= '0;
    else if (wr_ok) mode_q <= wr_data_i & RW_MASK;
  end

  assign mode_o             = mode_q;
  assign fields_o.ccs       = ccs_mode_e'(mode_q[CCS_LSB +: 2]);
  assign fields_o.multi     = mode_q[MULTI_B];
  assign fields_o.dir_read  = mode_q[DIR_B];
  assign fields_o.auto_stop = mode_q[ASTOP_B];
endmodule

// File: rtl/sd_xfer_blk_tracker.sv
module sd_xfer_blk_tracker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             blk_done_i,
  input  logic             multi_i,
  input  logic             auto_stop_i,
  output logic             stop_req_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;
  logic             active_q, armed_q, done_q, stop_q;
  logic             zero_cnt, last_blk;

  assign zero_cnt = multi_i && (blk_cnt_i == '0);
  // last block: counter about to reach zero
  assign last_blk = active_q && blk_done_i && (rem_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      if (start_i) begin
        armed_q  <= multi_i & auto_stop_i;
        rem_q    <= multi_i ? blk_cnt_i : ONE;
        active_q <= ~zero_cnt;
        done_q   <= zero_cnt;
      end else if (active_q && blk_done_i) begin
        rem_q <= rem_q - ONE;
        if (last_blk) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          stop_q   <= armed_q;
        end
      end
    end
  end

  assign stop_req_o = stop_q;
  assign done_o     = done_q;
endmodule

// File: rtl/sd_xfer_mode_ctrl.sv
module sd_xfer_mode_ctrl
  import sd_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [15:0]      wr_data_i,
  input  logic             dat_inhibit_i,
  input  logic             xfer_start_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             blk_done_i,
  output logic [15:0]      mode_o,
  output logic [1:0]       ccs_mode_o,
  output logic             multi_blk_o,
  output logic             dir_read_o,
  output logic             auto_stop_en_o,
  output logic             stop_req_o,
  output logic             xfer_done_o
);
  xfer_fields_t fields;

  sd_xfer_mode_reg u_reg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .dat_inhibit_i (dat_inhibit_i),
    .mode_o        (mode_o),
    .fields_o      (fields)
  );

  sd_xfer_blk_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (xfer_start_i),
    .blk_cnt_i   (blk_cnt_i),
    .blk_done_i  (blk_done_i),
    .multi_i     (fields.multi),
    .auto_stop_i (fields.auto_stop),
    .stop_req_o  (stop_req_o),
    .done_o      (xfer_done_o)
  );

  assign ccs_mode_o     = fields.ccs;
  assign multi_blk_o    = fields.multi;
  assign dir_read_o     = fields.dir_read;
  assign auto_stop_en_o = fields.auto_stop;
endmodule

// File: rtl/sd_xfer_mode_ctrl_chk.sv
module sd_xfer_mode_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [15:0]      wr_data_i,
  input logic             dat_inhibit_i,
  input logic             xfer_start_i,
  input logic [CNT_W-1:0] blk_cnt_i,
  input logic             blk_done_i,
  input logic [15:0]      mode_o,
  input logic [1:0]       ccs_mode_o,
  input logic             multi_blk_o,
  input logic             dir_read_o,
  input logic             auto_stop_en_o,
  input logic             stop_req_o,
  input logic             xfer_done_o
);
  p_wr_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_inhibit_i |=> $stable(mode_o));

  p_wr_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dat_inhibit_i) |=>
      (ccs_mode_o == $past(wr_data_i[9:8])) && (multi_blk_o == $past(wr_data_i[5]))
      && (dir_read_o == $past(wr_data_i[4])) && (auto_stop_en_o == $past(wr_data_i[2])));

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dat_inhibit_i) |=> ((mode_o & 16'hFCCB) == 16'h0));

  p_stop_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |=> !stop_req_o);

  p_stop_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |-> (xfer_done_o && $past(blk_done_i) && !$past(xfer_start_i)));

  p_zero_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && multi_blk_o && blk_cnt_i == '0) |=> (xfer_done_o && !stop_req_o));

  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && !(multi_blk_o && blk_cnt_i == '0)) |=> !xfer_done_o);
endmodule

bind sd_xfer_mode_ctrl sd_xfer_mode_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .dat_inhibit_i(dat_inhibit_i), .xfer_start_i(xfer_start_i), .blk_cnt_i(blk_cnt_i),
  .blk_done_i(blk_done_i), .mode_o(mode_o), .ccs_mode_o(ccs_mode_o),
  .multi_blk_o(multi_blk_o), .dir_read_o(dir_read_o), .auto_stop_en_o(auto_stop_en_o),
  .stop_req_o(stop_req_o), .xfer_done_o(xfer_done_o)
);

// File: tb/sd_xfer_mode_ctrl_test.sv
`timescale 1ns/1ps
module sd_xfer_mode_ctrl_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [15:0]      wr_data = '0;
  logic             inhibit = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] blk_cnt = '0;
  logic             blk_done = 1'b0;
  logic [15:0]      mode;
  logic [1:0]       ccs;
  logic             multi, dir_rd, astop, stop_req, done;

  int n_chk = 0, n_err = 0;

  // bench reference state
  logic [15:0]      e_mode = '0;
  logic [CNT_W-1:0] e_rem = '0;
  logic             e_act = 1'b0, e_arm = 1'b0, e_done = 1'b0, e_stop = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sd_xfer_mode_ctrl #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .dat_inhibit_i(inhibit), .xfer_start_i(start), .blk_cnt_i(blk_cnt),
    .blk_done_i(blk_done), .mode_o(mode), .ccs_mode_o(ccs), .multi_blk_o(multi),
    .dir_read_o(dir_rd), .auto_stop_en_o(astop), .stop_req_o(stop_req), .xfer_done_o(done)
  );

  function automatic logic [15:0] masked(input logic [15:0] d);
    return d & 16'h0334;  // R3: only bits 9,8,5,4,2 are stored
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 mode", mode, e_mode);
    chk("R2 ccs", 16'(ccs), 16'(e_mode[9:8]));
    chk("R2 multi", 16'(multi), 16'(e_mode[5]));
    chk("R2 dir", 16'(dir_rd), 16'(e_mode[4]));
    chk("R2 astop", 16'(astop), 16'(e_mode[2]));
    chk("R7 stop_req", 16'(stop_req), 16'(e_stop));
    chk("R6 done", 16'(done), 16'(e_done));
  endtask

  // one clock: drive after negedge, update reference at posedge, check after
  task automatic step(input logic we, input logic [15:0] wd, input logic inh,
                      input logic st, input logic [CNT_W-1:0] cnt, input logic bd);
    @(negedge clk);
    wr_en = we; wr_data = wd; inhibit = inh; start = st; blk_cnt = cnt; blk_done = bd;
    @(posedge clk);
    e_stop = 1'b0;
    if (st) begin
      e_arm = e_mode[5] & e_mode[2];
      e_rem = e_mode[5] ? cnt : CNT_W'(1);       // R5: count ignored for single
      e_act = !(e_mode[5] && cnt == '0);
      e_done = e_mode[5] && cnt == '0;           // R9 / R10
    end else if (bd && e_act) begin
      if (e_rem == CNT_W'(1)) begin
        e_act = 1'b0; e_done = 1'b1; e_stop = e_arm;  // R6, R7, R8
      end
      e_rem = e_rem - CNT_W'(1);
    end                                           // R11: idle strobe ignored
    if (we && !inh) e_mode = masked(wd);          // R4
    #2;
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    chk("R1 mode", mode, 16'h0);
    chk("R1 done", 16'(done), 16'h0);
    chk("R1 stop", 16'(stop_req), 16'h0);
    #20 rst_n = 1'b1;
    idle(2);

    // R2/R3: all ones written, reserved bits dropped
    step(1, 16'hFFFF, 0, 0, '0, 0);
    chk("R3 rsvd", mode & 16'hFCCB, 16'h0);
    // R2: each completion-signal encoding
    for (int c = 0; c < 4; c++) begin
      step(1, 16'(c) << 8, 0, 0, '0, 0);
      chk("R2 ccs enc", 16'(ccs), 16'(c));
    end
    // R4: write under inhibit ignored
    step(1, 16'h0034, 0, 0, '0, 0);
    step(1, 16'h0300, 1, 0, '0, 0);
    chk("R4 blocked", mode, 16'h0034);

    // R5/R8: single block with auto-stop set, count ignored
    step(1, 16'h0014, 0, 0, '0, 0);
    step(0, '0, 0, 1, 16'd9, 0);
    step(0, '0, 0, 0, '0, 1);
    chk("R5 single done", 16'(done), 16'h1);
    chk("R8 no stop single", 16'(stop_req), 16'h0);
    // R11: idle strobe
    step(0, '0, 0, 0, '0, 1);
    chk("R11 idle strobe", 16'(stop_req), 16'h0);

    // R6/R7: multi, auto, 3 blocks
    step(1, 16'h0024, 0, 0, '0, 0);
    step(0, '0, 0, 1, 16'd3, 0);
    chk("R10 cleared", 16'(done), 16'h0);
    step(0, '0, 1, 0, '0, 1);
    step(0, '0, 1, 0, '0, 1);
    chk("R6 not early", 16'(done), 16'h0);
    step(0, '0, 1, 0, '0, 1);
    chk("R7 stop pulse", 16'(stop_req), 16'h1);
    step(0, '0, 0, 0, '0, 0);
    chk("R7 one cycle", 16'(stop_req), 16'h0);

    // R9: multi zero count
    step(0, '0, 0, 1, '0, 0);
    chk("R9 zero done", 16'(done), 16'h1);
    step(0, '0, 0, 0, '0, 1);
    chk("R9 no stop", 16'(stop_req), 16'h0);

    // R8: multi without auto
    step(1, 16'h0020, 0, 0, '0, 0);
    step(0, '0, 0, 1, 16'd2, 0);
    step(0, '0, 0, 0, '0, 1);
    step(0, '0, 0, 0, '0, 1);
    chk("R8 no auto", 16'(stop_req), 16'h0);

    // random mix, fixed seed
    void'($urandom(32'h5D1C));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0] & r[1], 16'($urandom), r[2] & r[3], (r[7:4] == 4'h0),
           CNT_W'(r[10:8] % 6), r[11]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule